// File: doc/BRIEF.md
# Mode-banked register file

This block stores the integer registers and status words of a processor core that runs in one of seven operating modes. A program always names sixteen registers, r0 to r15, but which physical storage element answers depends on the current mode. The low eight registers and the program counter (r15) are common to every mode. The fast-interrupt mode owns a private copy of r8 to r12. Every exception mode owns its own stack pointer (r13) and link register (r14). The System mode shares all of its registers with User mode.

Next to the sixteen visible registers, the block keeps one current status word and one saved status word for each of the five exception modes. The current mode arrives as a 5-bit code from outside. An unknown code raises a flag and is served as an unprivileged User access. Two combinational read ports and one clocked write port serve the general registers. The status words have their own write strobes and always-visible outputs. Decode, arithmetic and exception sequencing sit in other blocks. This block only stores values and steers them by mode.

Top module: `banked_regfile`

## Requirements
- R1: While reset is active and straight after it, every register, the current status word and every saved status word read as zero.
- R2: r0 to r7 and r15 are single physical registers that all modes share, so a value written in one mode reads back in any other mode.
- R3: Mode code 10001 (fast interrupt) has its own r8 to r12. All other modes, including invalid codes, share one User copy of r8 to r12.
- R4: r13 and r14 have a separate copy for each of the codes 10000 (User), 10001, 10010, 10011, 10111 and 11011. Code 11111 (System) uses the User copies.
- R5: `modeBad` is 1 exactly when `modeIn` is none of the seven codes listed in R3 and R4. Such a code then accesses the User bank and counts as unprivileged.
- R6: Codes 10001, 10010, 10011, 10111 and 11011 each own one saved status word. `spsrOut` shows the word of the current mode, and `spsrWrEn` replaces that word at the clock edge.
- R7: In User, System or an invalid mode, `spsrOut` reads zero and `spsrWrEn` changes no saved status word.
- R8: In a privileged mode (any valid code except 10000), `cpsrWrEn` loads all 32 bits of `cpsrWrData` into the current status word.
- R9: In User or an invalid mode, `cpsrWrEn` updates only bits 31:28 (the condition flags). Bits 27:0 keep their value.
- R10: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R11: Both read ports decode their address independently against the same mode and may name any register at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeIn | input | 5 | Current mode code |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data, combinational |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data, combinational |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register number to write |
| wrData | input | 32 | Register write data |
| cpsrWrEn | input | 1 | Current status write strobe |
| cpsrWrData | input | 32 | Current status write data |
| spsrWrEn | input | 1 | Saved status write strobe for the current mode |
| spsrWrData | input | 32 | Saved status write data |
| cpsrOut | output | 32 | Current status word |
| spsrOut | output | 32 | Saved status word of the current mode, zero if none |
| modeBad | output | 1 | Current mode code is not a valid code |

## Verification
A wrong bank choice shows up only when a later read, made in a different mode, lands on the copy that the earlier write should or should not have touched. The stimulus therefore moves between modes between a write and its read-back, and every read port output is compared with a model keyed by mode and register. A wrong bank appears at the read ports in the first cycle in which the affected register is named. A status-gating fault appears on `cpsrOut` or `spsrOut` in the cycle after the write.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int MODE_W = 5;
  localparam int REG_AW = 4;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  // bank order also orders the r13/r14 pairs and the saved words
  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bankT;

  localparam int NUM_BANKS = 6;

  typedef struct packed {
    bankT bank;
    logic priv;
    logic hasSaved;
    logic gpWe;
    logic cpsrWeAll;
    logic cpsrWeFlags;
    logic spsrWe;
  } ctrlT;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] modeIn,
  input  logic              wrEn,
  input  logic              cpsrWrEn,
  input  logic              spsrWrEn,
  output ctrlT              ctl,
  output logic              modeBad
);
  bankT bank;
  logic priv;
  logic hasSaved;

  always_comb begin
    bank     = BK_USR;
    priv     = 1'b0;
    hasSaved = 1'b0;
    modeBad  = 1'b0;
    unique case (modeIn)
      MD_USR: ;
      MD_FIQ: begin bank = BK_FIQ; priv = 1'b1; hasSaved = 1'b1; end
      MD_IRQ: begin bank = BK_IRQ; priv = 1'b1; hasSaved = 1'b1; end
      MD_SVC: begin bank = BK_SVC; priv = 1'b1; hasSaved = 1'b1; end
      MD_ABT: begin bank = BK_ABT; priv = 1'b1; hasSaved = 1'b1; end
      MD_UND: begin bank = BK_UND; priv = 1'b1; hasSaved = 1'b1; end
      MD_SYS: priv = 1'b1;
      default: modeBad = 1'b1;
    endcase
  end

  always_comb begin
    ctl.bank        = bank;
    ctl.priv        = priv;
    ctl.hasSaved    = hasSaved;
    ctl.gpWe        = wrEn;
    ctl.cpsrWeAll   = cpsrWrEn & priv;
    ctl.cpsrWeFlags = cpsrWrEn & ~priv;
    ctl.spsrWe      = spsrWrEn & hasSaved;
  end
endmodule

// File: rtl/bank_dp.sv
module bank_dp
  import bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 4,
  parameter int NUM_COMMON = 8,
  parameter int NUM_HIGH = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctl,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] cpsrWrData,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] cpsrOut,
  output logic [DATA_W-1:0] spsrOut
);
  localparam int HIGH_FIQ  = NUM_COMMON + NUM_HIGH;
  localparam int PAIR_BASE = NUM_COMMON + 2 * NUM_HIGH;
  localparam int NUM_PHYS  = PAIR_BASE + 2 * NUM_BANKS + 1;
  localparam int PC_IDX    = NUM_PHYS - 1;
  localparam int NUM_SAVED = NUM_BANKS - 1;
  localparam int IDX_W     = $clog2(NUM_PHYS);
  localparam int SP_NUM    = NUM_COMMON + NUM_HIGH;
  localparam int PC_NUM    = (1 << REG_AW) - 1;

  function automatic logic [IDX_W-1:0] physIdx(bankT b, logic [REG_AW-1:0] a);
    int n;
    int r;
    n = int'(a);
    if (n < NUM_COMMON)           r = n;
    else if (n == PC_NUM)         r = PC_IDX;
    else if (n < SP_NUM)          r = (b == BK_FIQ) ? HIGH_FIQ + n - NUM_COMMON
                                                    : NUM_COMMON + n - NUM_COMMON;
    else                          r = PAIR_BASE + 2 * int'(b) + n - SP_NUM;
    return IDX_W'(r);
  endfunction

  logic [DATA_W-1:0] gpr   [NUM_PHYS];
  logic [DATA_W-1:0] saved [NUM_SAVED];
  logic [DATA_W-1:0] cpsr;
  logic [IDX_W-1:0]  idxA, idxB, idxW;

  assign idxA = physIdx(ctl.bank, rdAddrA);
  assign idxB = physIdx(ctl.bank, rdAddrB);
  assign idxW = physIdx(ctl.bank, wrAddr);

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  gpr[i] <= '0;
      else if (ctl.gpWe && idxW == IDX_W'(i))     gpr[i] <= wrData;
    end
  end

  for (genvar j = 0; j < NUM_SAVED; j++) begin : g_saved
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  saved[j] <= '0;
      else if (ctl.spsrWe && ctl.bank == bankT'(j + 1)) saved[j] <= spsrWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cpsr <= '0;
    else if (ctl.cpsrWeAll)   cpsr <= cpsrWrData;
    else if (ctl.cpsrWeFlags) cpsr[DATA_W-1 -: FLAG_W] <= cpsrWrData[DATA_W-1 -: FLAG_W];
  end

  always_comb begin
    spsrOut = '0;
    for (int j = 0; j < NUM_SAVED; j++)
      if (ctl.hasSaved && ctl.bank == bankT'(j + 1)) spsrOut = saved[j];
  end

  assign rdDataA = gpr[idxA];
  assign rdDataB = gpr[idxB];
  assign cpsrOut = cpsr;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeIn,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cpsrWrEn,
  input  logic [DATA_W-1:0] cpsrWrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] cpsrOut,
  output logic [DATA_W-1:0] spsrOut,
  output logic              modeBad
);
  ctrlT ctl;

  bank_ctrl u_ctrl (
    .modeIn(modeIn), .wrEn(wrEn), .cpsrWrEn(cpsrWrEn), .spsrWrEn(spsrWrEn),
    .ctl(ctl), .modeBad(modeBad)
  );

  bank_dp #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData),
    .cpsrWrData(cpsrWrData), .spsrWrData(spsrWrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .cpsrOut(cpsrOut), .spsrOut(spsrOut)
  );
endmodule

// File: rtl/bank_chk.sv
module bank_chk #(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        modeIn,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              cpsrWrEn,
  input logic [DATA_W-1:0] cpsrWrData,
  input logic [DATA_W-1:0] cpsrOut,
  input logic [DATA_W-1:0] spsrOut,
  input logic              modeBad
);
  logic modeOk, isUser, isSys;
  assign isUser = modeIn == 5'b10000;
  assign isSys  = modeIn == 5'b11111;
  assign modeOk = modeIn inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                 5'b10111, 5'b11011, 5'b11111};

  AST_MODE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    modeBad == !modeOk);                                                    // R5
  AST_SAVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (isUser || isSys || !modeOk) |-> spsrOut == '0);                        // R7
  AST_CPSR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (cpsrWrEn && modeOk && !isUser) |=> cpsrOut == $past(cpsrWrData));     // R8
  AST_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cpsrWrEn && (isUser || !modeOk)) |=>
      cpsrOut[DATA_W-FLAG_W-1:0] == $past(cpsrOut[DATA_W-FLAG_W-1:0]));    // R9
  AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'd15) ##1 (rdAddrA == 4'd15) |-> rdDataA == $past(wrData)); // R2
endmodule

bind banked_regfile bank_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeIn(modeIn), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cpsrWrEn(cpsrWrEn),
  .cpsrWrData(cpsrWrData), .cpsrOut(cpsrOut), .spsrOut(spsrOut), .modeBad(modeBad)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0]  modeIn = 5'b10000;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, cpsrWrEn = 1'b0, spsrWrEn = 1'b0;
  logic [31:0] cpsrWrData = '0, spsrWrData = '0, cpsrOut, spsrOut;
  logic        modeBad;

  int checks = 0;
  int failures = 0;

  always #(PERIOD / 2) clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rstN(rstN), .modeIn(modeIn),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpsrWrEn(cpsrWrEn), .cpsrWrData(cpsrWrData),
    .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData),
    .cpsrOut(cpsrOut), .spsrOut(spsrOut), .modeBad(modeBad)
  );

  // reference model, keyed by which copy a (mode, register) pair reaches
  logic [31:0] gprM [int];
  logic [31:0] savM [int];
  logic [31:0] cpsrM = '0;
  string cpsrTag = "R1";
  logic [4:0] modeList [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                               5'b10111, 5'b11011, 5'b11111};

  function automatic bit isValid(logic [4:0] m);
    return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
  endfunction

  function automatic bit hasSaved(logic [4:0] m);
    return isValid(m) && m != 5'b10000 && m != 5'b11111;
  endfunction

  function automatic int keyOf(logic [4:0] m, logic [3:0] r);
    logic [4:0] e;
    e = isValid(m) ? m : 5'b10000;
    if (e == 5'b11111) e = 5'b10000;
    if (r < 8 || r == 15) return int'(r);
    if (r <= 12) return (e == 5'b10001) ? 200 + int'(r) : int'(r);
    return int'(e) * 32 + int'(r);
  endfunction

  function automatic logic [31:0] gprGet(logic [4:0] m, logic [3:0] r);
    int k;
    k = keyOf(m, r);
    return gprM.exists(k) ? gprM[k] : 32'h0;
  endfunction

  function automatic logic [31:0] savGet(logic [4:0] m);
    if (!hasSaved(m)) return 32'h0;
    return savM.exists(int'(m)) ? savM[int'(m)] : 32'h0;
  endfunction

  function automatic string regTag(logic [3:0] r, bit sameCycleWrite);
    if (sameCycleWrite) return "R10";
    if (r < 8 || r == 15) return "R2";
    if (r <= 12) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [4:0] m, logic [3:0] a, logic [3:0] b,
                      logic we, logic [3:0] wa, logic [31:0] wd,
                      logic cwe, logic [31:0] cd, logic swe, logic [31:0] sd);
    @(negedge clk);
    modeIn = m; rdAddrA = a; rdAddrB = b;
    wrEn = we; wrAddr = wa; wrData = wd;
    cpsrWrEn = cwe; cpsrWrData = cd; spsrWrEn = swe; spsrWrData = sd;
    #1;
    chk(regTag(a, we && wa == a), rdDataA, gprGet(m, a));
    chk((we && wa == b) ? "R10" : "R11", rdDataB, gprGet(m, b));
    chk("R5", {31'b0, modeBad}, {31'b0, !isValid(m)});
    chk(cpsrTag, cpsrOut, cpsrM);
    chk(hasSaved(m) ? "R6" : "R7", spsrOut, savGet(m));
    @(posedge clk);
    #1;
    if (we) gprM[keyOf(m, wa)] = wd;
    if (cwe) begin
      if (isValid(m) && m != 5'b10000) begin cpsrM = cd; cpsrTag = "R8"; end
      else begin cpsrM[31:28] = cd[31:28]; cpsrTag = "R9"; end
    end
    if (swe && hasSaved(m)) savM[int'(m)] = sd;
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    // R1: reset state on every register number
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      rdAddrA = 4'(r); modeIn = modeList[r % 7];
      #1;
      chk("R1", rdDataA, 32'h0);
      chk("R1", spsrOut, 32'h0);
    end
    chk("R1", cpsrOut, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R10: same-cycle write/read of Supervisor r13, then read back
    step(5'b10011, 4'd13, 4'd13, 1, 4'd13, 32'hA5A5_0013, 0, 0, 0, 0);
    step(5'b10011, 4'd13, 4'd14, 0, 0, 0, 0, 0, 0, 0);
    // R4: System writes r14, User reads it; IRQ has its own
    step(5'b11111, 4'd14, 4'd0, 1, 4'd14, 32'h5151_0014, 0, 0, 0, 0);
    step(5'b10000, 4'd14, 4'd13, 0, 0, 0, 0, 0, 0, 0);
    step(5'b10010, 4'd14, 4'd13, 0, 0, 0, 0, 0, 0, 0);
    // R3: fast-interrupt r10 is private
    step(5'b10001, 4'd10, 4'd0, 1, 4'd10, 32'hF1F1_0010, 0, 0, 0, 0);
    step(5'b10000, 4'd10, 4'd10, 0, 0, 0, 0, 0, 0, 0);
    step(5'b10001, 4'd10, 4'd10, 0, 0, 0, 0, 0, 0, 0);
    // R2: program counter shared
    step(5'b11011, 4'd15, 4'd0, 1, 4'd15, 32'h0000_8000, 0, 0, 0, 0);
    step(5'b10000, 4'd15, 4'd15, 0, 0, 0, 0, 0, 0, 0);
    // R5: invalid code reads the User bank
    step(5'b00000, 4'd14, 4'd13, 0, 0, 0, 0, 0, 0, 0);
    // R6/R7: saved word of Supervisor survives a User write attempt
    step(5'b10011, 4'd0, 4'd0, 0, 0, 0, 0, 0, 1, 32'h0000_00D3);
    step(5'b10000, 4'd0, 4'd0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
    step(5'b11111, 4'd0, 4'd0, 0, 0, 0, 0, 0, 1, 32'hCAFE_F00D);
    step(5'b10011, 4'd0, 4'd0, 0, 0, 0, 0, 0, 0, 0);
    // R8 then R9: privileged full write, then User flags-only write
    step(5'b10011, 4'd0, 4'd0, 0, 0, 0, 1, 32'h1000_00D3, 0, 0);
    step(5'b10000, 4'd0, 4'd0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    step(5'b01010, 4'd0, 4'd0, 0, 0, 0, 1, 32'h0000_0000, 0, 0);
    step(5'b10000, 4'd0, 4'd0, 0, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [4:0] m;
      m = ($urandom_range(0, 9) == 0) ? 5'($urandom()) : modeList[$urandom_range(0, 6)];
      step(m, 4'($urandom()), 4'($urandom()),
           1'($urandom()), 4'($urandom()), $urandom(),
           ($urandom_range(0, 5) == 0), $urandom(),
           ($urandom_range(0, 4) == 0), $urandom());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule